// File: doc/BRIEF.md
# Two-Grid Display Dimming Timing Generator

This block drives a display that multiplexes two grids over a shared set of 23 segment lines. It runs from an oscillator-rate clock and splits every frame into two halves of equal length. The first half belongs to grid 1 and the second to grid 2. In each half, the active grid and the segments selected for that grid are enabled for a number of clocks set by a 10-bit dimming word. A short dark guard interval starts every half, so light never bleeds from one grid into the other.

The ON time is produced by a down counter. The counter is reloaded only at the start of a half, which keeps a dimming update from cutting a pulse short or stretching it. The dimming word is captured on a load strobe. When the reset is released, the captured word holds the maximum duty. Two overrides sit above the normal display path. The self-test input blinks all segments at maximum duty. The default-mode flag lights only the two lowest segments, at the last captured duty.

Top module: `vfd_duplex_dimmer`

## Requirements
- R1: While the reset is asserted, grid_n reads 2'b11 and seg_en reads 0. The reset release is synchronized over two clocks. Call clock n the n-th clock after those two. The frame position at clock n is then n-1 modulo 2048.
- R2: A frame lasts 2048 clocks. In positions 0..1023 only grid 1 may be active (grid_n[0]=0). In positions 1024..2047 only grid 2 may be active (grid_n[1]=0). Both grid_n bits are never low at the same time.
- R3: With a duty D, the grid of a half is active for exactly D clocks. These are half-relative positions 8 through 7+D.
- R4: A captured dimming value of 1016 or more gives a duty of 1016, so each half has at most 1016 active clocks.
- R5: A dimming value of 0 keeps both grids and all segments inactive for the whole frame.
- R6: A dimming value captured in the middle of a half leaves that half's pulse length unchanged. It takes effect at the start of the next half.
- R7: The first 8 clocks of every half have both grids and all segments inactive.
- R8: While grid 1 is active, seg_en equals disp_bits[22:0]. While grid 2 is active, seg_en equals disp_bits[45:23]. When no grid is active, seg_en is 0.
- R9: While test_n is 0, the duty is 1016 from the next half start, whatever the dimming word. During active clocks, seg_en is all ones for 2^(BLINK_LOG2-1) clocks from test entry, then all zeros for the same time, and this repeats. Test takes priority over default mode.
- R10: While dflt_mode is 1 and test_n is 1, seg_en during active clocks equals 23'h3 (segments 1 and 2) on both grids. The duty is the last value captured before default mode. A dim_load pulse during default mode is ignored.
- R11: After reset and before any dim_load, the captured duty is 1016. This holds in normal mode and in default mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_bits | input | 46 | Latched segment data: [22:0] for grid 1, [45:23] for grid 2 |
| dim_word | input | 10 | Dimming value, LSB = 1 clock of ON time |
| dim_load | input | 1 | Captures dim_word on this clock when dflt_mode is 0 |
| test_n | input | 1 | Active-low self-test select |
| dflt_mode | input | 1 | Default-mode display select |
| grid_n | output | 2 | Active-low grid enables |
| seg_en | output | 23 | Active-high segment enables |

## Verification
The hardest case to reach from the ports is a dimming update that arrives while a pulse is already running. The update must leave the current half intact and change only the following one. The bench counts clocks from the reset release and pulses dim_load at a known clock inside grid 1's window. It then measures the two halves of that frame separately against the old and new duties. The test-blink phase is aligned the same way: test_n drops exactly at a frame start, and the blink period is reduced by a parameter so that each blink phase covers one whole frame.

// File: rtl/vfdd_pkg.sv
package vfdd_pkg;
  // Source chosen for the segment lines during an active window
  typedef enum logic [1:0] {
    SEG_FROM_DISPLAY = 2'd0,
    SEG_FROM_DEFAULT = 2'd1,
    SEG_ALL_ON       = 2'd2,
    SEG_ALL_OFF      = 2'd3
  } seg_src_e;
endpackage

// File: rtl/vfdd_reset_sync.sv
module vfdd_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/vfdd_half_timer.sv
module vfdd_half_timer #(
  parameter int HALF_CLKS  = 1024,
  parameter int GUARD_CLKS = 8,
  parameter int GRIDS      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                half_start_o,
  output logic                guard_o,
  output logic [GIDX_W-1:0]   grid_idx_o
);
  localparam int POS_W  = $clog2(HALF_CLKS);
  localparam int GIDX_W = (GRIDS > 1) ? $clog2(GRIDS) : 1;
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(HALF_CLKS - 1);
  localparam logic [POS_W-1:0]  GUARD_V   = POS_W'(GUARD_CLKS);
  localparam logic [GIDX_W-1:0] LAST_GRID = GIDX_W'(GRIDS - 1);

  logic [POS_W-1:0]  pos_q, pos_d;
  logic [GIDX_W-1:0] idx_q, idx_d;
  logic              wrap;

  // next-state
  always_comb begin
    wrap  = (pos_q == LAST_POS);
    pos_d = wrap ? '0 : pos_q + POS_W'(1);
    idx_d = idx_q;
    if (wrap) begin
      idx_d = (idx_q == LAST_GRID) ? '0 : idx_q + GIDX_W'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      idx_q <= '0;
    end else begin
      pos_q <= pos_d;
      idx_q <= idx_d;
    end
  end

  assign half_start_o = (pos_q == '0);
  assign guard_o      = (pos_q < GUARD_V);
  assign grid_idx_o   = idx_q;

  // R2: position and grid index stay in range
  a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q <= LAST_POS) && (idx_q <= LAST_GRID));
  // R2: grid index advances only when a half wraps
  a_r2_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != LAST_POS) |=> (idx_q == $past(idx_q)));
endmodule

// File: rtl/vfdd_on_counter.sv
module vfdd_on_counter #(
  parameter int HALF_CLKS  = 1024,
  parameter int GUARD_CLKS = 8,
  parameter int DIM_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] dim_word,
  input  logic             dim_load,
  input  logic             dflt_mode,
  input  logic             test_n,
  input  logic             half_start_i,
  input  logic             guard_i,
  output logic             on_o
);
  localparam logic [DIM_W-1:0] MAX_ON_V = DIM_W'(HALF_CLKS - GUARD_CLKS);

  logic [DIM_W-1:0] held_q, held_d;
  logic [DIM_W-1:0] dwn_q, dwn_d;
  logic [DIM_W-1:0] duty_eff;
  logic             held_en, dwn_run;

  // capture of the dimming word (frozen during default mode)
  always_comb begin
    held_en = dim_load && !dflt_mode;
    held_d  = held_en ? dim_word : held_q;
  end

  // effective duty with clamp and test override
  always_comb begin
    if (!test_n) begin
      duty_eff = MAX_ON_V;
    end else if (held_q > MAX_ON_V) begin
      duty_eff = MAX_ON_V;
    end else begin
      duty_eff = held_q;
    end
  end

  // down counter: preset at half start, counts in the ON region
  always_comb begin
    dwn_run = !guard_i && (dwn_q != '0);
    dwn_d   = dwn_q;
    if (half_start_i) begin
      dwn_d = duty_eff;
    end else if (dwn_run) begin
      dwn_d = dwn_q - DIM_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= MAX_ON_V;
      dwn_q  <= '0;
    end else begin
      held_q <= held_d;
      dwn_q  <= dwn_d;
    end
  end

  assign on_o = dwn_run;

  // R4: count never exceeds clamped maximum
  a_r4_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    dwn_q <= MAX_ON_V);
  // R6: no preset away from half start
  a_r6_no_midload: assert property (@(posedge clk) disable iff (!rst_n)
    !half_start_i |=> (dwn_q <= $past(dwn_q)));
  // R10: captured value holds in default mode
  a_r10_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_mode |=> (held_q == $past(held_q)));
endmodule

// File: rtl/vfdd_seg_pattern.sv
module vfdd_seg_pattern
  import vfdd_pkg::*;
#(
  parameter int SEG_N      = 23,
  parameter int GRIDS      = 2,
  parameter int BLINK_LOG2 = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     test_n,
  input  logic                     dflt_mode,
  input  logic [SEG_N*GRIDS-1:0]   disp_bits,
  input  logic [GIDX_W-1:0]        grid_idx_i,
  input  logic                     on_i,
  output logic [SEG_N-1:0]         seg_next_o,
  output logic [GRIDS-1:0]         grid_next_o
);
  localparam int GIDX_W = (GRIDS > 1) ? $clog2(GRIDS) : 1;
  localparam logic [SEG_N-1:0] DFLT_SEGS = SEG_N'(3);

  logic [BLINK_LOG2-1:0] blink_q, blink_d;
  logic [SEG_N-1:0]      slice;
  seg_src_e              src;

  // blink timer, runs only in test mode
  always_comb begin
    blink_d = test_n ? '0 : blink_q + BLINK_LOG2'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blink_q <= '0;
    end else begin
      blink_q <= blink_d;
    end
  end

  // slice of display data owned by the active grid
  always_comb begin
    slice = '0;
    for (int g = 0; g < GRIDS; g++) begin
      if (grid_idx_i == GIDX_W'(g)) begin
        slice = disp_bits[g*SEG_N +: SEG_N];
      end
    end
  end

  // source select: test above default above display
  always_comb begin
    if (!test_n) begin
      src = blink_q[BLINK_LOG2-1] ? SEG_ALL_OFF : SEG_ALL_ON;
    end else if (dflt_mode) begin
      src = SEG_FROM_DEFAULT;
    end else begin
      src = SEG_FROM_DISPLAY;
    end
  end

  always_comb begin
    seg_next_o = '0;
    if (on_i) begin
      unique case (src)
        SEG_FROM_DISPLAY: seg_next_o = slice;
        SEG_FROM_DEFAULT: seg_next_o = DFLT_SEGS;
        SEG_ALL_ON:       seg_next_o = '1;
        SEG_ALL_OFF:      seg_next_o = '0;
        default:          seg_next_o = '0;
      endcase
    end
  end

  // one grid enable per grid
  for (genvar g = 0; g < GRIDS; g++) begin : g_grid
    assign grid_next_o[g] = on_i && (grid_idx_i == GIDX_W'(g));
  end

  // R9: blink timer idle outside test
  a_r9_blink_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(test_n) |-> (blink_q == '0));
endmodule

// File: rtl/vfd_duplex_dimmer.sv
module vfd_duplex_dimmer #(
  parameter int HALF_CLKS  = 1024,
  parameter int GUARD_CLKS = 8,
  parameter int DIM_W      = 10,
  parameter int SEG_N      = 23,
  parameter int GRIDS      = 2,
  parameter int BLINK_LOG2 = 19
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEG_N*GRIDS-1:0] disp_bits,
  input  logic [DIM_W-1:0]       dim_word,
  input  logic                   dim_load,
  input  logic                   test_n,
  input  logic                   dflt_mode,
  output logic [GRIDS-1:0]       grid_n,
  output logic [SEG_N-1:0]       seg_en
);
  localparam int GIDX_W = (GRIDS > 1) ? $clog2(GRIDS) : 1;

  logic              rst_i_n;
  logic              half_start_w, guard_w, on_w;
  logic [GIDX_W-1:0] grid_idx_w;
  logic [SEG_N-1:0]  seg_next_w, seg_q;
  logic [GRIDS-1:0]  grid_next_w, grid_en_q;

  vfdd_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  vfdd_half_timer #(
    .HALF_CLKS (HALF_CLKS),
    .GUARD_CLKS(GUARD_CLKS),
    .GRIDS     (GRIDS)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .half_start_o(half_start_w),
    .guard_o     (guard_w),
    .grid_idx_o  (grid_idx_w)
  );

  vfdd_on_counter #(
    .HALF_CLKS (HALF_CLKS),
    .GUARD_CLKS(GUARD_CLKS),
    .DIM_W     (DIM_W)
  ) u_on (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .dim_word    (dim_word),
    .dim_load    (dim_load),
    .dflt_mode   (dflt_mode),
    .test_n      (test_n),
    .half_start_i(half_start_w),
    .guard_i     (guard_w),
    .on_o        (on_w)
  );

  vfdd_seg_pattern #(
    .SEG_N     (SEG_N),
    .GRIDS     (GRIDS),
    .BLINK_LOG2(BLINK_LOG2)
  ) u_pat (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .test_n     (test_n),
    .dflt_mode  (dflt_mode),
    .disp_bits  (disp_bits),
    .grid_idx_i (grid_idx_w),
    .on_i       (on_w),
    .seg_next_o (seg_next_w),
    .grid_next_o(grid_next_w)
  );

  // output registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      grid_en_q <= '0;
      seg_q     <= '0;
    end else begin
      grid_en_q <= grid_next_w;
      seg_q     <= seg_next_w;
    end
  end

  assign grid_n = ~grid_en_q;
  assign seg_en = seg_q;

  // R2: at most one grid at a time
  a_r2_one_grid: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(grid_en_q));
  // R8: segments dark whenever no grid is enabled
  a_r8_dark_segs: assert property (@(posedge clk) disable iff (!rst_i_n)
    (grid_en_q == '0) |-> (seg_q == '0));
  // R7: guard clocks give dark outputs
  a_r7_guard_dark: assert property (@(posedge clk) disable iff (!rst_i_n)
    guard_w |=> (grid_en_q == '0));
  // R10: default pattern during active clocks
  a_r10_dflt_segs: assert property (@(posedge clk) disable iff (!rst_i_n)
    (on_w && test_n && dflt_mode) |=> (seg_q == SEG_N'(3)));
endmodule

// File: tb/vfd_duplex_dimmer_tb.sv
module vfd_duplex_dimmer_tb_top;
  localparam int H  = 1024;
  localparam int G  = 8;
  localparam int FR = 2 * H;

  logic        clk, rst_n;
  logic [45:0] disp_bits;
  logic [9:0]  dim_word;
  logic        dim_load, test_n, dflt_mode;
  logic [1:0]  grid_n;
  logic [22:0] seg_en;

  int n_chk = 0;
  int n_fail = 0;
  int ecnt;
  bit done = 0;

  vfd_duplex_dimmer #(.BLINK_LOG2(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_bits(disp_bits), .dim_word(dim_word),
    .dim_load(dim_load), .test_n(test_n), .dflt_mode(dflt_mode),
    .grid_n(grid_n), .seg_en(seg_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  // {expected duty, dimming word, display bits}
  localparam logic [65:0] VECS [6] = '{
    {10'd1016, 10'd1023, 46'h1555_5555_5555},
    {10'd1016, 10'd1016, 46'h3FFF_FFFF_FFFF},
    {10'd1015, 10'd1015, 46'h0000_007F_FFFF},
    {10'd0,    10'd0,    46'h2AAA_AAAA_AAAA},
    {10'd1,    10'd1,    46'h3FFF_FF80_0000},
    {10'd600,  10'd600,  46'h0123_4567_89AB}
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_fs();
    while (ecnt < 2 || ((ecnt - 2) % FR) != 0) @(negedge clk);
  endtask

  task automatic load_dim(input logic [9:0] v);
    dim_word = v;
    dim_load = 1'b1;
    @(negedge clk);
    dim_load = 1'b0;
    repeat (FR - 1) @(negedge clk);
  endtask

  // Measures one frame starting at a frame-start negedge.
  task automatic measure_frame(input int d1, input int d2,
                               input logic [22:0] s1, input logic [22:0] s2,
                               input int chg_at, input logic [9:0] chg_val,
                               input string tag);
    int on1, on2, win_bad, seg_bad, bad_act, bad_exp;
    bit e1, e2;
    logic [22:0] es;
    on1 = 0; on2 = 0; win_bad = 0; seg_bad = 0; bad_act = 0; bad_exp = 0;
    for (int i = 1; i <= FR; i++) begin
      @(posedge clk);
      @(negedge clk);
      e1 = (i >= G + 1) && (i <= G + d1);
      e2 = (i >= H + G + 1) && (i <= H + G + d2);
      es = e1 ? s1 : (e2 ? s2 : 23'h0);
      if (!grid_n[0]) on1++;
      if (!grid_n[1]) on2++;
      if ((!grid_n[0]) != e1 || (!grid_n[1]) != e2) win_bad++;
      if (seg_en != es) begin
        if (seg_bad == 0) begin bad_act = int'(seg_en); bad_exp = int'(es); end
        seg_bad++;
      end
      if (i == chg_at) begin dim_word = chg_val; dim_load = 1'b1; end
      if (i == chg_at + 1) dim_load = 1'b0;
    end
    chk(on1 == d1 && win_bad == 0, {tag, " grid1 on clocks"}, on1, d1);
    chk(on2 == d2 && win_bad == 0, {tag, " grid2 on clocks"}, on2, d2);
    chk(seg_bad == 0, {tag, " segment pattern"}, bad_act, bad_exp);
  endtask

  initial begin
    rst_n = 1'b0; disp_bits = 46'h3FFF_0000_FFFF; dim_word = 10'd0;
    dim_load = 1'b0; test_n = 1'b1; dflt_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(grid_n == 2'b11 && seg_en == 23'h0, "R1 reset outputs", int'({grid_n, seg_en}), int'({2'b11, 23'h0}));
    rst_n = 1'b1;
    wait_fs();
    // R11/R3/R7: no load yet, maximum duty; window start covers guard
    measure_frame(1016, 1016, disp_bits[22:0], disp_bits[45:23], -1, 10'd0, "R11 R3 R7 R2 power-up duty");

    // table of vectors: R3 R4 R5 R8
    for (int k = 0; k < 6; k++) begin
      disp_bits = VECS[k][45:0];
      load_dim(VECS[k][55:46]);
      measure_frame(int'(VECS[k][65:56]), int'(VECS[k][65:56]),
                    VECS[k][22:0], VECS[k][45:23], -1, 10'd0,
                    $sformatf("R3 R4 R5 R8 vec%0d", k));
    end

    // R6: change in the middle of grid 1's pulse
    disp_bits = 46'h3FFF_FFFF_FFFF;
    load_dim(10'd600);
    measure_frame(600, 200, 23'h7FFFFF, 23'h7FFFFF, 300, 10'd200, "R6 mid-pulse update");

    // R10: default mode, load during default ignored
    dflt_mode = 1'b1;
    measure_frame(200, 200, 23'h3, 23'h3, 100, 10'd900, "R10 default mode");

    // R9: test mode blink, priority over default
    dflt_mode = 1'b0; test_n = 1'b0; dim_word = 10'd100;
    measure_frame(1016, 1016, 23'h7FFFFF, 23'h7FFFFF, -1, 10'd0, "R9 test blink on");
    measure_frame(1016, 1016, 23'h0, 23'h0, -1, 10'd0, "R9 test blink off");
    dflt_mode = 1'b1;
    measure_frame(1016, 1016, 23'h7FFFFF, 23'h7FFFFF, -1, 10'd0, "R9 test over default");
    test_n = 1'b1;
    measure_frame(200, 200, 23'h3, 23'h3, -1, 10'd0, "R10 after test held duty");

    // R11: reset straight into default mode
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(grid_n == 2'b11 && seg_en == 23'h0, "R1 second reset outputs", int'({grid_n, seg_en}), int'({2'b11, 23'h0}));
    rst_n = 1'b1;
    wait_fs();
    measure_frame(1016, 1016, 23'h3, 23'h3, -1, 10'd0, "R11 default after reset");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule